// File: doc/BRIEF.md
# Bit Test and Modify Unit

A sequential helper for an 8-bit accumulator CPU core. The core hands it one operation at a time: an operation code, the memory operand, the accumulator, an immediate byte and a 3-bit bit index. The unit returns four things one cycle later:

- the byte to write back to memory, with a write enable;
- the Negative, Overflow and Zero flags;
- a branch decision for branches that depend on a single bit.

The unit supports three mask tests, setting or clearing one indexed bit, and branching on one indexed bit. Memory sequencing, instruction fetch, decode and the branch-target adder are left to the core.

A single valid/ready pair accepts work. The result register then holds its output until the consumer takes it. The flags are state inside the unit. Only the three test operations change them, so the flags persist across every other operation.

Top module: `btm_unit`

## Requirements
- R1: Operation code 0 (mask test) gives `out_data` = memory AND immediate, with `out_we` = 0.
- R2: Operation code 1 (test and set) gives `out_data` = memory OR accumulator, with `out_we` = 1.
- R3: Operation code 2 (test and clear) gives `out_data` = memory AND NOT accumulator, with `out_we` = 1.
- R4: After codes 0, 1 or 2, `flag_n` equals memory bit 7 and `flag_v` equals memory bit 6 of the original operand. `flag_z` is 1 exactly when `out_data` is zero.
- R5: Code 3 clears bit `in_idx` of the memory byte and code 4 sets it. Both leave the other bits as they are and drive `out_we` = 1.
- R6: Code 5 sets `out_taken` when bit `in_idx` of memory is 0, and code 6 sets it when that bit is 1. Both give `out_we` = 0 and `out_data` = memory. For every other code, `out_taken` is 0.
- R7: Codes 3 to 7 leave all three flags unchanged. Code 7 is a no-op that passes memory through with `out_we` = 0.
- R8: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its result appears with `out_valid` = 1 on the next cycle. `in_ready` = !`out_valid` or `out_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_we` and `out_taken` hold their values.
- R10: During and after reset, `out_valid`, `out_we`, `out_taken` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | Operation code (see R1 to R7) |
| in_mem | input | 8 | Memory operand |
| in_acc | input | 8 | Accumulator |
| in_imm | input | 8 | Immediate mask |
| in_idx | input | 3 | Bit index |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Write-back byte |
| out_we | output | 1 | Write-back enable |
| out_taken | output | 1 | Bit branch taken |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions assume that the consumer never needs `out_valid` to drop without a handshake. They also assume that operation codes arrive only in cycles where `in_valid` is high, because flag stability is checked only on accepted requests. The stimulus changes inputs only on falling edges and drops `in_valid` after each accepted request. It stalls `out_ready` for a random few cycles so the hold behaviour is exercised. Operands, indices and codes are drawn with `$urandom` from a fixed seed. All eight codes are covered, along with directed all-zero, all-one and edge-index bytes.

// File: rtl/btm_pkg.sv
package btm_pkg;
   typedef enum logic [2:0] {
      OP_TST_IMM = 3'd0,
      OP_TST_SET = 3'd1,
      OP_TST_CLR = 3'd2,
      OP_BIT_CLR = 3'd3,
      OP_BIT_SET = 3'd4,
      OP_BR_CLR  = 3'd5,
      OP_BR_SET  = 3'd6,
      OP_NONE    = 3'd7
   } btm_op_e;
endpackage

// File: rtl/btm_bitsel.sv
module btm_bitsel #(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] mask
);
   for (genvar g = 0; g < DATA_W; g++) begin : g_dec
      assign mask[g] = (idx == IDX_W'(g));
   end
endmodule

// File: rtl/btm_alu.sv
module btm_alu
   import btm_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] mem,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] imm,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] res,
   output logic              we,
   output logic              taken,
   output logic              upd,
   output logic              n_new,
   output logic              v_new,
   output logic              z_new
);
   logic bit_on;
   assign bit_on = |(mem & mask);

   always_comb begin
      res   = mem;
      we    = 1'b0;
      taken = 1'b0;
      upd   = 1'b0;
      case (btm_op_e'(op))
         OP_TST_IMM: begin res = mem & imm;  upd = 1'b1; end
         OP_TST_SET: begin res = mem | acc;  upd = 1'b1; we = 1'b1; end
         OP_TST_CLR: begin res = mem & ~acc; upd = 1'b1; we = 1'b1; end
         OP_BIT_CLR: begin res = mem & ~mask; we = 1'b1; end
         OP_BIT_SET: begin res = mem | mask;  we = 1'b1; end
         OP_BR_CLR:  taken = ~bit_on;
         OP_BR_SET:  taken = bit_on;
         default:    ;
      endcase
   end

   assign n_new = mem[DATA_W-1];
   assign v_new = mem[DATA_W-2];
   assign z_new = (res == '0);
endmodule

// File: rtl/btm_unit.sv
module btm_unit
   import btm_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [2:0]        in_op,
   input  logic [DATA_W-1:0] in_mem,
   input  logic [DATA_W-1:0] in_acc,
   input  logic [DATA_W-1:0] in_imm,
   input  logic [IDX_W-1:0]  in_idx,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_we,
   output logic              out_taken,
   output logic              flag_n,
   output logic              flag_v,
   output logic              flag_z
);
   if (DATA_W < 2 || (1 << IDX_W) != DATA_W) begin : g_bad_width
      $error("btm_unit: DATA_W must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mask, res;
   logic we, taken, upd, n_new, v_new, z_new, fire;

   btm_bitsel #(.DATA_W(DATA_W)) u_sel (.idx(in_idx), .mask(mask));

   btm_alu #(.DATA_W(DATA_W)) u_alu (
      .op(in_op), .mem(in_mem), .acc(in_acc), .imm(in_imm), .mask(mask),
      .res(res), .we(we), .taken(taken), .upd(upd),
      .n_new(n_new), .v_new(v_new), .z_new(z_new)
   );

   assign in_ready = !out_valid || out_ready;
   assign fire     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_we    <= 1'b0;
         out_taken <= 1'b0;
         flag_n    <= 1'b0;
         flag_v    <= 1'b0;
         flag_z    <= 1'b0;
      end else begin
         if (fire) begin
            out_valid <= 1'b1;
            out_data  <= res;
            out_we    <= we;
            out_taken <= taken;
            if (upd) begin
               flag_n <= n_new;
               flag_v <= v_new;
               flag_z <= z_new;
            end
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid); // R8
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we) && $stable(out_taken))); // R9
   AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && in_op >= 3'd3) |=> $stable({flag_n, flag_v, flag_z})); // R7
   AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (in_op == 3'd0 || in_op >= 3'd5)) |=> !out_we); // R6
   AST_TAKEN_BRANCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && in_op != 3'd5 && in_op != 3'd6) |=> !out_taken); // R6
   AST_BIT_OP_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (in_op == 3'd3 || in_op == 3'd4)) |-> $countones(res ^ in_mem) <= 1); // R5
endmodule

// File: tb/btm_unit_tb.sv
module btm_unit_tb;
   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, out_ready = 1'b1;
   logic [2:0] in_op = '0, in_idx = '0;
   logic [7:0] in_mem = '0, in_acc = '0, in_imm = '0;
   logic in_ready, out_valid, out_we, out_taken, flag_n, flag_v, flag_z;
   logic [7:0] out_data;
   int checks = 0, fails = 0;
   logic en, ev, ez;

   always #4 clk = ~clk;

   btm_unit u_dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [2:0] op, input logic [7:0] m, a, i,
                      input logic [2:0] ix, input int hold);
      logic [7:0] r; logic w, t; string tag;
      r = m; w = 0; t = 0;
      case (op)
         3'd0: begin r = m & i;  tag = "R1"; end
         3'd1: begin r = m | a;  w = 1; tag = "R2"; end
         3'd2: begin r = m & ~a; w = 1; tag = "R3"; end
         3'd3: begin r = m & ~(8'd1 << ix); w = 1; tag = "R5"; end
         3'd4: begin r = m | (8'd1 << ix);  w = 1; tag = "R5"; end
         3'd5: begin t = ~m[ix]; tag = "R6"; end
         3'd6: begin t = m[ix];  tag = "R6"; end
         default: tag = "R7";
      endcase
      if (op <= 3'd2) begin en = m[7]; ev = m[6]; ez = (r == 0); end
      @(negedge clk);
      in_op = op; in_mem = m; in_acc = a; in_imm = i; in_idx = ix;
      in_valid = 1; out_ready = (hold == 0);
      @(negedge clk);
      in_valid = 0;
      chk("R8 out_valid", out_valid, 1);
      chk({tag, " data"}, out_data, r);
      chk({tag, " we"}, out_we, w);
      chk({tag, " taken"}, out_taken, t);
      chk(op <= 3'd2 ? "R4 flags" : "R7 flags", {flag_n, flag_v, flag_z}, {en, ev, ez});
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk("R9 hold", {out_valid, in_ready, out_data, out_we, out_taken}, {1'b1, 1'b0, r, w, t});
      end
      out_ready = 1;
      @(negedge clk);
      chk("R8 drain", out_valid, 0);
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      void'($urandom(1234));
      en = 0; ev = 0; ez = 0;
      #3;
      chk("R10 reset", {out_valid, out_we, out_taken, flag_n, flag_v, flag_z}, 6'b0);
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R10 after reset", {out_valid, out_we, out_taken, flag_n, flag_v, flag_z, in_ready}, 7'b1);
      run(3'd0, 8'hC0, 8'h00, 8'h3F, 0, 0);   // R1, R4 zero result with N,V set
      run(3'd1, 8'h00, 8'h00, 8'h00, 0, 0);   // R2 all zero
      run(3'd2, 8'hFF, 8'hFF, 8'h00, 0, 2);   // R3 clear all, R9
      run(3'd4, 8'h00, 8'h00, 8'h00, 3'd7, 0); // R5 top bit
      run(3'd3, 8'hFF, 8'h00, 8'h00, 3'd0, 0); // R5 bottom bit
      run(3'd5, 8'hFE, 8'h00, 8'h00, 3'd0, 0); // R6 taken
      run(3'd6, 8'h7F, 8'h00, 8'h00, 3'd7, 0); // R6 not taken
      run(3'd7, 8'h5A, 8'hFF, 8'hFF, 3'd2, 1); // R7 no-op
      for (int n = 0; n < 400; n++)
         run(3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom),
             ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule